// File: doc/BRIEF.md
# AXI4-Lite Control and Status Register Bank

This block is a small memory-mapped register bank reached through an AXI4-Lite slave port. It claims a 32-byte window that starts at a configurable base address. Inside that window it holds six 32-bit words:

- a packed control word with three fields;
- a full-width configuration word;
- a status word that mixes a hardware-owned byte with a software-owned byte;
- a write-only command word;
- a 64-bit hardware count, split over two consecutive words.

Each field and word drives its own output toward the logic it controls. Three single-cycle pulses tell that logic when the control word or the command word was written, and when the status word was read. The status read pulse is meant for clear-on-read handling.

The registers live in the bus clock domain. When crossing is enabled, two sets of flip-flop chains of configurable length connect them to a separate logic clock:

- register outputs are retimed into the logic clock domain;
- hardware inputs are retimed into the bus clock domain.

The three pulses stay in the bus clock domain.

Top module: `rb_regbank`

## Requirements
- R1: After reset, the words read as follows: control 0x00004021, configuration 0xCAFEBABE, and status {16'h0, 8'h10, hardware level}. The logic-side outputs show run=1, mode=2, speed=0x40, configuration 0xCAFEBABE, threshold 0x10 and command 0.
- R2: The registers sit at base+0x00 (control), base+0x04 (configuration), base+0x08 (status), base+0x0C (command), base+0x10 (count low) and base+0x14 (count high). An address outside the 32-byte window reads 0 and ignores writes. The same holds for an unmapped word inside the window.
- R3: The configuration word is read/write, and write byte-lane strobes are honoured lane by lane (WSTRB bit i covers data bits 8i+7:8i).
- R4: The control word packs run at bit 0, a 2-bit mode at bits 5:4 and an 8-bit speed at bits 15:8. All other bits read 0 and ignore writes. Each field drives its own output.
- R5: In the status word, bits 7:0 always read the hardware level input and ignore software writes. Bits 15:8 are a software-writable threshold with its own output.
- R6: The command word is write-only: a write reaches the command output, and a read returns 0.
- R7: The 64-bit hardware count reads with bits 31:0 at base+0x10 and bits 63:32 at base+0x14.
- R8: The control-word and command-word write strobes each pulse for exactly one cycle, in the cycle after the write response handshake. A write to any byte of the word raises the strobe, and a write to another word does not.
- R9: The status read strobe pulses for exactly one cycle, together with the first cycle of read-data valid, only for reads of the status word.
- R10: Every write and read response is OKAY (2'b00). BVALID and RVALID, once raised, hold until accepted, and read data stays stable meanwhile.
- R11: With crossing enabled, a register write reaches the logic-side outputs only after SYNC_STAGES logic-clock edges (2 to 5). Hardware inputs appear in reads after SYNC_STAGES bus-clock edges.
- R12: If a read and a write of the same word complete on the same clock edge, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| arst | input | 1 | Synchronous active-high reset, bus domain |
| lclk | input | 1 | Logic clock |
| lrst | input | 1 | Synchronous active-high reset, logic domain |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte-lane strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| hw_level | input | 8 | Hardware-owned status byte (logic domain) |
| hw_count | input | 64 | Hardware 64-bit count (logic domain) |
| run_en | output | 1 | Control run field (logic domain) |
| run_mode | output | 2 | Control mode field (logic domain) |
| run_speed | output | 8 | Control speed field (logic domain) |
| cfg_word | output | 32 | Configuration word (logic domain) |
| sts_thresh | output | 8 | Status threshold field (logic domain) |
| cmd_word | output | 32 | Command word (logic domain) |
| ctrl_wstb | output | 1 | Control-word write pulse (bus domain) |
| cmd_wstb | output | 1 | Command-word write pulse (bus domain) |
| sts_rstb | output | 1 | Status-word read pulse (bus domain) |

## Verification
The read path and the write path are independent, so a read and a write of the same word can both be accepted on one clock edge. The bench provokes this by raising the address and data valids of both channels in the same cycle, aimed at the configuration word. The read data is then judged against the value held before the write, and a later read must show the new value. A second overlap exists between hardware updates of the status level byte and a software write to the same word. The bench writes all ones there and then changes the level, expecting only the threshold byte to follow software.

// File: rtl/rb_regbank_pkg.sv
package rb_regbank_pkg;

  localparam int REG_W  = 32;
  localparam int STRB_W = REG_W / 8;
  localparam int IDX_W  = 3;
  localparam int MAP_BITS = IDX_W + 2;

  // word indices inside the window; count low must precede count high
  localparam logic [IDX_W-1:0] W_CTRL   = 3'd0;
  localparam logic [IDX_W-1:0] W_CFG    = 3'd1;
  localparam logic [IDX_W-1:0] W_STS    = 3'd2;
  localparam logic [IDX_W-1:0] W_CMD    = 3'd3;
  localparam logic [IDX_W-1:0] W_CNT_LO = 3'd4;
  localparam logic [IDX_W-1:0] W_CNT_HI = 3'd5;

  // control word layout
  localparam int RUN_LSB   = 0;
  localparam int MODE_LSB  = 4;
  localparam int MODE_W    = 2;
  localparam int SPEED_LSB = 8;
  localparam int SPEED_W   = 8;
  localparam logic               RUN_RST   = 1'b1;
  localparam logic [MODE_W-1:0]  MODE_RST  = 2'd2;
  localparam logic [SPEED_W-1:0] SPEED_RST = 8'h40;

  localparam logic [REG_W-1:0] CTRL_MASK =
      (REG_W'(1) << RUN_LSB) |
      (REG_W'((1 << MODE_W) - 1) << MODE_LSB) |
      (REG_W'((1 << SPEED_W) - 1) << SPEED_LSB);

  localparam logic [REG_W-1:0] CTRL_RST =
      (REG_W'(RUN_RST) << RUN_LSB) |
      (REG_W'(MODE_RST) << MODE_LSB) |
      (REG_W'(SPEED_RST) << SPEED_LSB);

  localparam logic [REG_W-1:0] CFG_RST = 32'hCAFE_BABE;

  // status word layout
  localparam int LVL_W   = 8;
  localparam int LVL_LSB = 0;
  localparam int THR_W   = 8;
  localparam int THR_LSB = 8;
  localparam logic [THR_W-1:0] THR_RST = 8'h10;

  localparam int CNT_W = 64;

  typedef struct packed {
    logic               run;
    logic [MODE_W-1:0]  mode;
    logic [SPEED_W-1:0] speed;
    logic [REG_W-1:0]   cfg;
    logic [THR_W-1:0]   thr;
    logic [REG_W-1:0]   cmd;
  } ctl_out_t;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [CNT_W-1:0] cnt;
  } hw_in_t;

  function automatic logic [REG_W-1:0] lane_mask(input logic [STRB_W-1:0] s);
    logic [REG_W-1:0] m;
    for (int i = 0; i < STRB_W; i++) m[i*8 +: 8] = {8{s[i]}};
    return m;
  endfunction

endpackage

// File: rtl/rb_sync_chain.sv
module rb_sync_chain #(
  parameter int W = 8,
  parameter int STAGES = 3,
  parameter bit EN = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (EN) begin : g_sync
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
        stg[0] <= d;
        for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
    end

    assign q = stg[STAGES-1];
  end else begin : g_bypass
    assign q = d;
  end

endmodule

// File: rtl/rb_axil_front.sv
module rb_axil_front #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic              b_done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);

  assign s_bresp = 2'b00;
  assign s_rresp = 2'b00;

  assign wr_en   = s_awvalid && s_awready && s_wvalid && s_wready;
  assign wr_addr = s_awaddr;
  assign wr_data = s_wdata;
  assign wr_strb = s_wstrb;
  assign b_done  = s_bvalid && s_bready;
  assign rd_en   = s_arvalid && s_arready;
  assign rd_addr = s_araddr;

  // write channel: address and data are taken together, one at a time
  always_ff @(posedge clk) begin
    if (rst) begin
      s_awready <= 1'b0;
      s_wready  <= 1'b0;
      s_bvalid  <= 1'b0;
    end else begin
      if (wr_en) begin
        s_awready <= 1'b0;
        s_wready  <= 1'b0;
        s_bvalid  <= 1'b1;
      end else if (s_awvalid && s_wvalid && !s_awready && !s_bvalid) begin
        s_awready <= 1'b1;
        s_wready  <= 1'b1;
      end
      if (b_done) s_bvalid <= 1'b0;
    end
  end

  // read channel: data is captured in the accept cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      s_arready <= 1'b0;
      s_rvalid  <= 1'b0;
      s_rdata   <= '0;
    end else begin
      if (rd_en) begin
        s_arready <= 1'b0;
        s_rvalid  <= 1'b1;
        s_rdata   <= rd_data;
      end else if (s_arvalid && !s_arready && !s_rvalid) begin
        s_arready <= 1'b1;
      end
      if (s_rvalid && s_rready) s_rvalid <= 1'b0;
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid); // R10
  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R10
  AST_ONE_WRITE_OPEN: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> !wr_en); // R10

endmodule

// File: rtl/rb_regfile.sv
module rb_regfile
  import rb_regbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic              b_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  hw_in_t            hw,
  output ctl_out_t          ctl,
  output logic              ctrl_wstb,
  output logic              cmd_wstb,
  output logic              sts_rstb
);

  logic             wr_hit, rd_hit;
  logic [IDX_W-1:0] widx, ridx;
  logic [REG_W-1:0] wm;
  logic [REG_W-1:0] ctrl_q, cfg_q, cmd_q;
  logic [THR_W-1:0] thr_q;
  logic             pend_ctrl, pend_cmd;
  logic             unused_lo;

  assign wr_hit = wr_addr[ADDR_W-1:MAP_BITS] == BASE_ADDR[ADDR_W-1:MAP_BITS];
  assign rd_hit = rd_addr[ADDR_W-1:MAP_BITS] == BASE_ADDR[ADDR_W-1:MAP_BITS];
  assign widx   = wr_addr[MAP_BITS-1:2];
  assign ridx   = rd_addr[MAP_BITS-1:2];
  assign wm     = lane_mask(wr_strb);
  assign unused_lo = ^{wr_addr[1:0], rd_addr[1:0]};

  logic we_ctrl, we_cfg, we_sts, we_cmd;
  assign we_ctrl = wr_en && wr_hit && (widx == W_CTRL);
  assign we_cfg  = wr_en && wr_hit && (widx == W_CFG);
  assign we_sts  = wr_en && wr_hit && (widx == W_STS);
  assign we_cmd  = wr_en && wr_hit && (widx == W_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      cfg_q  <= CFG_RST;
      thr_q  <= THR_RST;
      cmd_q  <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= (ctrl_q & ~(wm & CTRL_MASK)) | (wr_data & wm & CTRL_MASK);
      if (we_cfg)  cfg_q  <= (cfg_q & ~wm) | (wr_data & wm);
      if (we_sts)  thr_q  <= (thr_q & ~wm[THR_LSB +: THR_W]) |
                             (wr_data[THR_LSB +: THR_W] & wm[THR_LSB +: THR_W]);
      if (we_cmd)  cmd_q  <= (cmd_q & ~wm) | (wr_data & wm);
    end
  end

  // strobes: whole-word, raised after the response handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ctrl <= 1'b0;
      pend_cmd  <= 1'b0;
      ctrl_wstb <= 1'b0;
      cmd_wstb  <= 1'b0;
      sts_rstb  <= 1'b0;
    end else begin
      if (we_ctrl)     pend_ctrl <= 1'b1;
      else if (b_done) pend_ctrl <= 1'b0;
      if (we_cmd)      pend_cmd  <= 1'b1;
      else if (b_done) pend_cmd  <= 1'b0;
      ctrl_wstb <= b_done && pend_ctrl;
      cmd_wstb  <= b_done && pend_cmd;
      sts_rstb  <= rd_en && rd_hit && (ridx == W_STS);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      case (ridx)
        W_CTRL:   rd_data = ctrl_q;
        W_CFG:    rd_data = cfg_q;
        W_STS: begin
          rd_data[LVL_LSB +: LVL_W] = hw.lvl;
          rd_data[THR_LSB +: THR_W] = thr_q;
        end
        W_CNT_LO: rd_data = hw.cnt[REG_W-1:0];
        W_CNT_HI: rd_data = hw.cnt[CNT_W-1:REG_W];
        default:  rd_data = '0;
      endcase
    end
  end

  assign ctl.run   = ctrl_q[RUN_LSB];
  assign ctl.mode  = ctrl_q[MODE_LSB +: MODE_W];
  assign ctl.speed = ctrl_q[SPEED_LSB +: SPEED_W];
  assign ctl.cfg   = cfg_q;
  assign ctl.thr   = thr_q;
  assign ctl.cmd   = cmd_q;

  AST_OOM_IGNORED: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_hit |=> $stable(cfg_q) && $stable(ctrl_q) && $stable(thr_q) && $stable(cmd_q)); // R2
  AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    we_ctrl |=> (ctrl_q & ~CTRL_MASK) == '0); // R4
  AST_WSTB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wstb |=> !ctrl_wstb); // R8
  AST_WSTB_AFTER_B: assert property (@(posedge clk) disable iff (rst)
    cmd_wstb |-> $past(b_done)); // R8
  AST_RSTB_AFTER_AR: assert property (@(posedge clk) disable iff (rst)
    sts_rstb |-> $past(rd_en)); // R9

endmodule

// File: rtl/rb_regbank.sv
module rb_regbank
  import rb_regbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1000,
  parameter bit SYNC_EN = 1'b1,
  parameter int SYNC_STAGES = 3
) (
  input  logic               aclk,
  input  logic               arst,
  input  logic               lclk,
  input  logic               lrst,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [REG_W-1:0]   s_wdata,
  input  logic [STRB_W-1:0]  s_wstrb,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [ADDR_W-1:0]  s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [REG_W-1:0]   s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  input  logic [LVL_W-1:0]   hw_level,
  input  logic [CNT_W-1:0]   hw_count,
  output logic               run_en,
  output logic [MODE_W-1:0]  run_mode,
  output logic [SPEED_W-1:0] run_speed,
  output logic [REG_W-1:0]   cfg_word,
  output logic [THR_W-1:0]   sts_thresh,
  output logic [REG_W-1:0]   cmd_word,
  output logic               ctrl_wstb,
  output logic               cmd_wstb,
  output logic               sts_rstb
);

  localparam ctl_out_t CTL_RST = '{run: RUN_RST, mode: MODE_RST, speed: SPEED_RST,
                                   cfg: CFG_RST, thr: THR_RST, cmd: '0};
  localparam int CTL_W = $bits(ctl_out_t);
  localparam int HW_W  = $bits(hw_in_t);

  logic              wr_en, rd_en, b_done;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [REG_W-1:0]  wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  hw_in_t            hw_raw, hw_bus;
  ctl_out_t          ctl_bus, ctl_log;

  rb_axil_front #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_front (
    .clk(aclk), .rst(arst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .b_done(b_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rb_regfile #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(aclk), .rst(arst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .b_done(b_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hw(hw_bus), .ctl(ctl_bus),
    .ctrl_wstb(ctrl_wstb), .cmd_wstb(cmd_wstb), .sts_rstb(sts_rstb)
  );

  assign hw_raw.lvl = hw_level;
  assign hw_raw.cnt = hw_count;

  // logic domain -> bus domain
  rb_sync_chain #(.W(HW_W), .STAGES(SYNC_STAGES), .EN(SYNC_EN), .RST_VAL('0)) u_sync_in (
    .clk(aclk), .rst(arst), .d(hw_raw), .q(hw_bus)
  );

  // bus domain -> logic domain
  rb_sync_chain #(.W(CTL_W), .STAGES(SYNC_STAGES), .EN(SYNC_EN), .RST_VAL(CTL_RST)) u_sync_out (
    .clk(lclk), .rst(lrst), .d(ctl_bus), .q(ctl_log)
  );

  assign run_en     = ctl_log.run;
  assign run_mode   = ctl_log.mode;
  assign run_speed  = ctl_log.speed;
  assign cfg_word   = ctl_log.cfg;
  assign sts_thresh = ctl_log.thr;
  assign cmd_word   = ctl_log.cmd;

endmodule

// File: tb/sim_rb_regbank.sv
module sim_rb_regbank;

  localparam logic [15:0] A_CTRL = 16'h1000;
  localparam logic [15:0] A_CFG  = 16'h1004;
  localparam logic [15:0] A_STS  = 16'h1008;
  localparam logic [15:0] A_CMD  = 16'h100C;
  localparam logic [15:0] A_CLO  = 16'h1010;
  localparam logic [15:0] A_CHI  = 16'h1014;

  logic aclk = 1'b0, lclk = 1'b0, arst = 1'b1, lrst = 1'b1;
  logic [15:0] s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic        s_bready = 1'b1, s_rready = 1'b1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [7:0]  hw_level = 8'h5A;
  logic [63:0] hw_count = '0;
  logic        run_en, ctrl_wstb, cmd_wstb, sts_rstb;
  logic [1:0]  run_mode;
  logic [7:0]  run_speed, sts_thresh;
  logic [31:0] cfg_word, cmd_word;

  int n_run = 0;
  int n_fail = 0;

  always #5 aclk = ~aclk;
  always #7 lclk = ~lclk;

  rb_regbank u0 (
    .aclk(aclk), .arst(arst), .lclk(lclk), .lrst(lrst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .hw_level(hw_level), .hw_count(hw_count),
    .run_en(run_en), .run_mode(run_mode), .run_speed(run_speed),
    .cfg_word(cfg_word), .sts_thresh(sts_thresh), .cmd_word(cmd_word),
    .ctrl_wstb(ctrl_wstb), .cmd_wstb(cmd_wstb), .sts_rstb(sts_rstb)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge aclk);
  endtask

  task automatic axi_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s,
                           output logic wc, output logic wm, output logic [1:0] resp);
    @(negedge aclk);
    s_awaddr = a; s_awvalid = 1'b1; s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
    do @(negedge aclk); while (!s_awready);
    @(negedge aclk);
    resp = s_bresp;
    chk("R10 bvalid raised", s_bvalid, 1);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    @(negedge aclk);
    wc = ctrl_wstb; wm = cmd_wstb;
    @(negedge aclk);
    chk("R8 write strobe width", {ctrl_wstb, cmd_wstb}, 0);
  endtask

  task automatic axi_read(input logic [15:0] a, output logic [31:0] d,
                          output logic [1:0] resp, output logic rs);
    @(negedge aclk);
    s_araddr = a; s_arvalid = 1'b1;
    do @(negedge aclk); while (!s_arready);
    @(negedge aclk);
    s_arvalid = 1'b0;
    d = s_rdata; resp = s_rresp; rs = sts_rstb;
    @(negedge aclk);
    chk("R9 read strobe width", sts_rstb, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [1:0] r; logic rs;
    chk("R1 run", run_en, 1);
    chk("R1 mode", run_mode, 2);
    chk("R1 speed", run_speed, 8'h40);
    chk("R1 cfg out", cfg_word, 32'hCAFEBABE);
    chk("R1 thresh", sts_thresh, 8'h10);
    chk("R1 cmd", cmd_word, 0);
    idle(6);
    axi_read(A_CTRL, d, r, rs); chk("R1 ctrl read", d, 32'h0000_4021);
    axi_read(A_CFG, d, r, rs);  chk("R1 cfg read", d, 32'hCAFEBABE);
    axi_read(A_STS, d, r, rs);  chk("R1 status read", d, 32'h0000_105A);
  endtask

  task automatic t_cfg_bytes;
    logic [31:0] d; logic [1:0] r; logic wc, wm, rs;
    axi_write(A_CFG, 32'h1234_5678, 4'hF, wc, wm, r);
    chk("R10 bresp", r, 2'b00);
    chk("R8 no strobe on cfg", {wc, wm}, 0);
    axi_read(A_CFG, d, r, rs); chk("R3 full write", d, 32'h1234_5678);
    chk("R10 rresp", r, 2'b00);
    axi_write(A_CFG, 32'hAABB_CCDD, 4'b0101, wc, wm, r);
    axi_read(A_CFG, d, r, rs); chk("R3 lanes 0 and 2", d, 32'h12BB_56DD);
  endtask

  task automatic t_ctrl_pack;
    logic [31:0] d; logic [1:0] r; logic wc, wm, rs;
    axi_write(A_CTRL, 32'hFFFF_FFFF, 4'hF, wc, wm, r);
    chk("R8 ctrl strobe", {wc, wm}, 2'b10);
    axi_read(A_CTRL, d, r, rs); chk("R4 packed bits only", d, 32'h0000_FF31);
    idle(10);
    chk("R4 run out", run_en, 1);
    chk("R4 mode out", run_mode, 3);
    chk("R4 speed out", run_speed, 8'hFF);
    axi_write(A_CTRL, 32'h0000_0000, 4'b0001, wc, wm, r);
    chk("R8 strobe on byte 0 only", {wc, wm}, 2'b10);
    axi_read(A_CTRL, d, r, rs); chk("R4 low byte cleared", d, 32'h0000_FF00);
    idle(10);
    chk("R4 run cleared", run_en, 0);
    chk("R4 mode cleared", run_mode, 0);
    chk("R4 speed kept", run_speed, 8'hFF);
  endtask

  task automatic t_status;
    logic [31:0] d; logic [1:0] r; logic wc, wm, rs;
    axi_write(A_STS, 32'hFFFF_FFFF, 4'hF, wc, wm, r);
    axi_read(A_STS, d, r, rs);
    chk("R5 ro byte kept", d, 32'h0000_FF5A);
    chk("R9 status read strobe", rs, 1);
    hw_level = 8'h33;
    idle(6);
    axi_read(A_STS, d, r, rs); chk("R5 ro byte follows hw", d, 32'h0000_FF33);
    axi_read(A_CTRL, d, r, rs); chk("R9 no strobe on ctrl read", rs, 0);
    idle(10);
    chk("R5 thresh out", sts_thresh, 8'hFF);
  endtask

  task automatic t_cmd;
    logic [31:0] d; logic [1:0] r; logic wc, wm, rs;
    axi_write(A_CMD, 32'hDEAD_BEEF, 4'hF, wc, wm, r);
    chk("R8 cmd strobe", {wc, wm}, 2'b01);
    axi_read(A_CMD, d, r, rs); chk("R6 write-only reads 0", d, 0);
    idle(10);
    chk("R6 cmd out", cmd_word, 32'hDEAD_BEEF);
  endtask

  task automatic t_count;
    logic [31:0] d; logic [1:0] r; logic rs;
    hw_count = 64'h0123_4567_89AB_CDEF;
    idle(6);
    axi_read(A_CLO, d, r, rs); chk("R7 count low", d, 32'h89AB_CDEF);
    axi_read(A_CHI, d, r, rs); chk("R7 count high", d, 32'h0123_4567);
  endtask

  task automatic t_outside;
    logic [31:0] d; logic [1:0] r; logic wc, wm, rs;
    axi_write(16'h2004, 32'hFFFF_FFFF, 4'hF, wc, wm, r);
    chk("R10 bresp outside", r, 2'b00);
    axi_write(16'h1018, 32'hFFFF_FFFF, 4'hF, wc, wm, r);
    axi_read(A_CFG, d, r, rs); chk("R2 cfg untouched", d, 32'h12BB_56DD);
    axi_read(A_CTRL, d, r, rs); chk("R2 ctrl untouched", d, 32'h0000_FF00);
    axi_read(16'h2004, d, r, rs); chk("R2 outside reads 0", d, 0);
    chk("R10 rresp outside", r, 2'b00);
    axi_read(16'h1018, d, r, rs); chk("R2 unmapped reads 0", d, 0);
  endtask

  task automatic t_sync;
    logic [1:0] r; logic wc, wm;
    idle(10);
    chk("R11 cfg out before", cfg_word, 32'h12BB_56DD);
    axi_write(A_CFG, 32'h0F0F_0F0F, 4'hF, wc, wm, r);
    chk("R11 cfg out not yet", cfg_word, 32'h12BB_56DD);
    idle(10);
    chk("R11 cfg out after", cfg_word, 32'h0F0F_0F0F);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d; logic [1:0] r, rw; logic wc, wm, rs;
    fork
      axi_write(A_CFG, 32'h55AA_55AA, 4'hF, wc, wm, rw);
      axi_read(A_CFG, d, r, rs);
    join
    chk("R12 read sees old value", d, 32'h0F0F_0F0F);
    axi_read(A_CFG, d, r, rs);
    chk("R12 later read sees new", d, 32'h55AA_55AA);
  endtask

  initial begin
    repeat (5) @(negedge aclk);
    arst = 1'b0; lrst = 1'b0;
    @(negedge aclk);
    t_reset();
    t_cfg_bytes();
    t_ctrl_pack();
    t_status();
    t_cmd();
    t_count();
    t_outside();
    t_sync();
    t_same_cycle();
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge aclk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule